// File: doc/BRIEF.md
# Parity-Conditional Call and Return Sequencer

This block is the control sequencer for an 8-bit processor core with 16-bit addressing. It runs two instructions against a byte-wide memory bus. The first is a call taken only when the parity flag shows an odd result. The second is the matching return. Every other opcode is treated as a one-byte no-operation, so the program counter keeps advancing through memory. The block holds the program counter and the stack pointer. A load port can overwrite both at any time and restart fetching from the new address.

One clock equals one bus state. The opcode fetch drives the read strobe for three states and then spends internal states with no strobe: one state for most opcodes, three for the call. Every later memory read or write lasts three states. A taken call fetches its two target bytes and pushes the return address high byte first onto a stack that grows toward lower addresses. It then jumps to the target. The return pops the low byte and then the high byte. The parity flag arrives on an input from the arithmetic unit: 1 means an even number of set bits and 0 means an odd number.

Top module: `pcs_top`

## Requirements
- R1: A synchronous reset puts the sequencer in the first state of an opcode fetch, with PC = 0x0000 and SP = 0x0000, the read strobe high and the address at 0x0000.
- R2: An opcode fetch keeps the read strobe high at address PC for 3 states. Any opcode other than 0xE4 and 0xC9 then ends after one internal state (4 states in total) with PC increased by 1 and no write.
- R3: Opcode 0xE4 with parity_in = 0 when the low operand read ends takes 18 states. These are fetch (6, strobe in the first 3), read PC+1 (target low byte), read PC+2 (target high byte), write SP-1, write SP-2 (3 each). Afterwards PC is the target and SP is lowered by 2.
- R4: Opcode 0xE4 with parity_in = 1 (even) takes 9 states: the 6-state fetch and one read of the low operand. There is no write. PC ends at the call's address + 3 and SP is unchanged.
- R5: A taken call writes the high byte of (call address + 3) at SP-1 and then the low byte at SP-2.
- R6: Opcode 0xC9 takes 10 states. These are a 4-state fetch, a read at SP (new PC low byte) and a read at SP+1 (new PC high byte). PC then takes the popped value and SP rises by 2.
- R7: Stack pointer arithmetic wraps modulo 2^16 for both pushes and pops.
- R8: Read and write strobes are never high together. Through each 3-state write cycle, the write data and the address hold constant.
- R9: ld_en has priority over sequencing. In the next state, PC = ld_pc and SP = ld_sp, and a fresh opcode fetch begins. Any unfinished instruction is abandoned.
- R10: insn_end is high exactly in the last state of each instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bus state per cycle |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Load PC and SP and restart fetching |
| ld_pc | input | 16 | PC value taken when ld_en is high |
| ld_sp | input | 16 | SP value taken when ld_en is high |
| parity_in | input | 1 | Parity flag: 1 even, 0 odd number of ones |
| mem_rdata | input | 8 | Read data from memory |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Write data to memory |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| pc_out | output | 16 | Current program counter |
| sp_out | output | 16 | Current stack pointer |
| insn_end | output | 1 | Last state of an instruction |

## Verification
The assertions assume two things about the inputs. First, mem_rdata is valid in the last state of each read cycle. Second, parity_in is steady when the low operand read of a call ends. Properties that follow a cycle boundary are qualified by ld_en being low, because a load may cut any cycle short. The bench keeps within these assumptions: it updates read data half a clock after each address change, and it sets parity_in only at the start of an instruction, from an 8-bit subtraction linked to that instruction's address. Loads are timed to land both at instruction boundaries and inside an unfinished call.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_OPLO,
        ST_OPHI,
        ST_PUSHHI,
        ST_PUSHLO,
        ST_POPLO,
        ST_POPHI
    } pcs_state_e;

    localparam logic [7:0] OPC_CALL_PO = 8'hE4;
    localparam logic [7:0] OPC_RET     = 8'hC9;

endpackage

// File: rtl/pcs_fsm.sv
module pcs_fsm
    import pcs_pkg::*;
#(
    parameter int DW         = 8,
    parameter int TW         = 3,
    parameter int CALL_FETCH = 6,
    parameter int BASE_FETCH = 4,
    parameter int MEM_LEN    = 3,
    parameter int SAMPLE_T   = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic [DW-1:0] ir,
    input  logic          parity,
    output pcs_state_e    st_q,
    output logic [TW-1:0] tcnt_q,
    output logic          cyc_last,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic          insn_end
);

    pcs_state_e nxt;
    int         cyc_len;
    logic       is_call;
    logic       is_ret;

    // Cycle length and successor state
    always_comb begin
        is_call = (ir == OPC_CALL_PO);
        is_ret  = (ir == OPC_RET);
        cyc_len = MEM_LEN;
        nxt     = st_q;
        unique case (st_q)
            ST_FETCH: begin
                cyc_len = is_call ? CALL_FETCH : BASE_FETCH;
                if (is_call)     nxt = ST_OPLO;
                else if (is_ret) nxt = ST_POPLO;
                else             nxt = ST_FETCH;
            end
            ST_OPLO:   nxt = parity ? ST_FETCH : ST_OPHI;
            ST_OPHI:   nxt = ST_PUSHHI;
            ST_PUSHHI: nxt = ST_PUSHLO;
            ST_PUSHLO: nxt = ST_FETCH;
            ST_POPLO:  nxt = ST_POPHI;
            ST_POPHI:  nxt = ST_FETCH;
            default:   nxt = ST_FETCH;
        endcase
        cyc_last = (int'(tcnt_q) == cyc_len - 1);
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst || restart) begin
            st_q   <= ST_FETCH;
            tcnt_q <= '0;
        end else if (cyc_last) begin
            st_q   <= nxt;
            tcnt_q <= '0;
        end else begin
            tcnt_q <= tcnt_q + TW'(1);
        end
    end

    // Strobes and instruction end
    always_comb begin
        mem_rd = 1'b0;
        mem_wr = 1'b0;
        unique case (st_q)
            ST_FETCH:  mem_rd = (int'(tcnt_q) <= SAMPLE_T);
            ST_OPLO, ST_OPHI, ST_POPLO, ST_POPHI: mem_rd = 1'b1;
            ST_PUSHHI, ST_PUSHLO: mem_wr = 1'b1;
            default: ;
        endcase
        insn_end = cyc_last && (nxt == ST_FETCH);
    end

endmodule

// File: rtl/pcs_dp.sv
module pcs_dp
    import pcs_pkg::*;
#(
    parameter int AW       = 16,
    parameter int DW       = 8,
    parameter int TW       = 3,
    parameter int SAMPLE_T = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_en,
    input  logic [AW-1:0] ld_pc,
    input  logic [AW-1:0] ld_sp,
    input  logic          parity,
    input  logic [DW-1:0] mem_rdata,
    input  pcs_state_e    st,
    input  logic [TW-1:0] tcnt,
    input  logic          cyc_last,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic [AW-1:0] pc_q,
    output logic [AW-1:0] sp_q,
    output logic [DW-1:0] ir_q,
    output logic [DW-1:0] lo_q
);

    logic [DW-1:0] hi_q;
    logic          sample;

    assign sample = (int'(tcnt) == SAMPLE_T);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
            sp_q <= '0;
            ir_q <= '0;
            lo_q <= '0;
            hi_q <= '0;
        end else if (ld_en) begin
            pc_q <= ld_pc;
            sp_q <= ld_sp;
            ir_q <= '0;
        end else begin
            unique case (st)
                ST_FETCH: if (sample) begin
                    ir_q <= mem_rdata;
                    pc_q <= pc_q + AW'(1);
                end
                ST_OPLO: if (sample) begin
                    lo_q <= mem_rdata;
                    // a failed condition also skips the high operand byte
                    pc_q <= pc_q + ((cyc_last && parity) ? AW'(2) : AW'(1));
                end
                ST_OPHI: if (sample) begin
                    hi_q <= mem_rdata;
                    pc_q <= pc_q + AW'(1);
                end
                ST_PUSHHI: if (cyc_last) sp_q <= sp_q - AW'(1);
                ST_PUSHLO: if (cyc_last) begin
                    sp_q <= sp_q - AW'(1);
                    pc_q <= {hi_q, lo_q};
                end
                ST_POPLO: if (sample) begin
                    lo_q <= mem_rdata;
                    sp_q <= sp_q + AW'(1);
                end
                ST_POPHI: if (sample) begin
                    pc_q <= {mem_rdata, lo_q};
                    sp_q <= sp_q + AW'(1);
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        mem_wdata = '0;
        unique case (st)
            ST_PUSHHI, ST_PUSHLO: mem_addr = sp_q - AW'(1);
            ST_POPLO, ST_POPHI:   mem_addr = sp_q;
            default:              mem_addr = pc_q;
        endcase
        if (st == ST_PUSHHI) mem_wdata = pc_q[AW-1 -: DW];
        if (st == ST_PUSHLO) mem_wdata = pc_q[DW-1:0];
    end

endmodule

// File: rtl/pcs_top.sv
module pcs_top
    import pcs_pkg::*;
#(
    parameter int AW         = 16,
    parameter int DW         = 8,
    parameter int CALL_FETCH = 6,
    parameter int BASE_FETCH = 4,
    parameter int MEM_LEN    = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_en,
    input  logic [AW-1:0] ld_pc,
    input  logic [AW-1:0] ld_sp,
    input  logic          parity_in,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [AW-1:0] pc_out,
    output logic [AW-1:0] sp_out,
    output logic          insn_end
);

    localparam int TW       = $clog2(CALL_FETCH);
    localparam int SAMPLE_T = MEM_LEN - 1;

    pcs_state_e    st;
    logic [TW-1:0] tcnt;
    logic          cyc_last;
    logic [DW-1:0] ir;
    logic [DW-1:0] lo_byte;

    pcs_fsm #(
        .DW(DW), .TW(TW), .CALL_FETCH(CALL_FETCH), .BASE_FETCH(BASE_FETCH),
        .MEM_LEN(MEM_LEN), .SAMPLE_T(SAMPLE_T)
    ) u_fsm (
        .clk(clk), .rst(rst), .restart(ld_en), .ir(ir), .parity(parity_in),
        .st_q(st), .tcnt_q(tcnt), .cyc_last(cyc_last),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .insn_end(insn_end)
    );

    pcs_dp #(
        .AW(AW), .DW(DW), .TW(TW), .SAMPLE_T(SAMPLE_T)
    ) u_dp (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_pc(ld_pc), .ld_sp(ld_sp),
        .parity(parity_in), .mem_rdata(mem_rdata), .st(st), .tcnt(tcnt),
        .cyc_last(cyc_last), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .pc_q(pc_out), .sp_q(sp_out), .ir_q(ir), .lo_q(lo_byte)
    );

endmodule

// File: rtl/pcs_chk.sv
module pcs_chk
    import pcs_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int TW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          ld_en,
    input logic [AW-1:0] ld_pc,
    input logic [AW-1:0] ld_sp,
    input logic          parity_in,
    input logic [DW-1:0] mem_rdata,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic [AW-1:0] pc_out,
    input logic [AW-1:0] sp_out,
    input logic          insn_end,
    input pcs_state_e    st,
    input logic [TW-1:0] tcnt,
    input logic          cyc_last,
    input logic [DW-1:0] lo_byte
);

    assert_reset_fetch_R1: assert property (@(posedge clk)
        rst |=> (st == ST_FETCH && tcnt == '0 && pc_out == '0 && sp_out == '0 && mem_rd));

    assert_fetch_addr_R2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_FETCH && tcnt == '0) |-> (mem_rd && mem_addr == pc_out));

    assert_push_order_R3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_PUSHHI && cyc_last && !ld_en)
            |=> (st == ST_PUSHLO && mem_addr == $past(mem_addr) - AW'(1)));

    assert_skip_call_R4: assert property (@(posedge clk) disable iff (rst)
        (st == ST_OPLO && cyc_last && parity_in && !ld_en)
            |=> (st == ST_FETCH && pc_out == $past(pc_out) + AW'(2)));

    assert_ret_load_R6: assert property (@(posedge clk) disable iff (rst)
        (st == ST_POPHI && cyc_last && !ld_en)
            |=> (pc_out == {$past(mem_rdata), $past(lo_byte)} && sp_out == $past(sp_out) + AW'(1)));

    assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_rd, mem_wr}));

    assert_wdata_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && !cyc_last && !ld_en)
            |=> (mem_wr && $stable(mem_wdata) && $stable(mem_addr)));

    assert_load_R9: assert property (@(posedge clk) disable iff (rst)
        ld_en |=> (pc_out == $past(ld_pc) && sp_out == $past(ld_sp) && st == ST_FETCH && tcnt == '0));

    assert_insn_end_R10: assert property (@(posedge clk) disable iff (rst)
        (insn_end && !ld_en) |=> (st == ST_FETCH && tcnt == '0));

endmodule

bind pcs_top pcs_chk #(.AW(AW), .DW(DW), .TW(TW)) u_chk (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_pc(ld_pc), .ld_sp(ld_sp),
    .parity_in(parity_in), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .pc_out(pc_out), .sp_out(sp_out), .insn_end(insn_end),
    .st(st), .tcnt(tcnt), .cyc_last(cyc_last), .lo_byte(lo_byte)
);

// File: tb/sim_pcs_top.sv
module sim_pcs_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_en = 1'b0;
    logic [15:0] ld_pc = '0;
    logic [15:0] ld_sp = '0;
    logic        parity_in = 1'b1;
    logic [7:0]  mem_rdata = '0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_rd;
    logic        mem_wr;
    logic [15:0] pc_out;
    logic [15:0] sp_out;
    logic        insn_end;

    always #10 clk = ~clk;

    pcs_top u0 (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_pc(ld_pc), .ld_sp(ld_sp),
        .parity_in(parity_in), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .pc_out(pc_out), .sp_out(sp_out), .insn_end(insn_end)
    );

    int checks = 0;
    int fails  = 0;

    logic [7:0] mem  [int];
    logic [7:0] mmem [int];

    typedef struct {
        bit          rd;
        bit          wr;
        bit          chk_addr;
        logic [15:0] addr;
        logic [7:0]  wd;
        bit          last;
        bit          first;
        logic [15:0] pc;
        logic [15:0] sp;
        string       tag;
    } ent_t;

    ent_t        q[$];
    logic [15:0] mpc = '0;
    logic [15:0] msp = '0;
    string       ovr = "";

    function automatic logic [7:0] dut_byte(logic [15:0] a);
        return mem.exists(int'(a)) ? mem[int'(a)] : 8'h00;
    endfunction

    function automatic logic [7:0] ref_byte(logic [15:0] a);
        return mmem.exists(int'(a)) ? mmem[int'(a)] : 8'h00;
    endfunction

    // parity of an 8-bit subtraction tied to each instruction address (1 = even)
    function automatic bit par_for(logic [15:0] a);
        logic [7:0] r;
        case (a)
            16'h2000: r = 8'h40 - 8'h30;
            16'h2003: r = 8'h33 - 8'h30;
            16'h2006: r = 8'h47 - 8'h40;
            16'h2100: r = 8'h20 - 8'h1F;
            default:  r = 8'h03;
        endcase
        return ~^r;
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic put(logic [15:0] a, logic [7:0] d);
        mem[int'(a)]  = d;
        mmem[int'(a)] = d;
    endtask

    task automatic push_e(bit rd, bit wr, bit ca, logic [15:0] a, logic [7:0] wd, bit last, string tag);
        ent_t e;
        e.rd = rd; e.wr = wr; e.chk_addr = ca; e.addr = a; e.wd = wd;
        e.last = last; e.first = 1'b0; e.pc = '0; e.sp = '0; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic push_n(int n, bit rd, bit wr, logic [15:0] a, logic [7:0] wd, bit last, string tag);
        for (int i = 0; i < n; i++)
            push_e(rd, wr, 1'b1, a, wd, last && (i == n - 1), tag);
    endtask

    // behavioural model: expand the next instruction into per-state bus entries
    task automatic gen();
        logic [15:0] p, s, ret;
        logic [7:0]  op, lo, hi;
        int          base;
        bit          par;
        p = mpc; s = msp; base = q.size();
        op = ref_byte(p);
        par = par_for(p);
        parity_in = par;
        if (op == 8'hE4) begin
            push_n(3, 1, 0, p, 0, 0, "R3");
            for (int i = 0; i < 3; i++) push_e(0, 0, 0, 0, 0, 0, "R3");
            lo = ref_byte(p + 16'd1);
            if (par) begin
                push_n(3, 1, 0, p + 16'd1, 0, 1, "R4");
                mpc = p + 16'd3;
            end else begin
                push_n(3, 1, 0, p + 16'd1, 0, 0, "R3");
                hi = ref_byte(p + 16'd2);
                push_n(3, 1, 0, p + 16'd2, 0, 0, "R3");
                ret = p + 16'd3;
                push_n(3, 0, 1, s - 16'd1, ret[15:8], 0, "R5");
                push_n(3, 0, 1, s - 16'd2, ret[7:0], 1, "R5");
                mpc = {hi, lo};
                msp = s - 16'd2;
            end
        end else if (op == 8'hC9) begin
            push_n(3, 1, 0, p, 0, 0, "R6");
            push_e(0, 0, 0, 0, 0, 0, "R6");
            push_n(3, 1, 0, s, 0, 0, "R6");
            push_n(3, 1, 0, s + 16'd1, 0, 1, "R6");
            mpc = {ref_byte(s + 16'd1), ref_byte(s)};
            msp = s + 16'd2;
        end else begin
            push_n(3, 1, 0, p, 0, 0, "R2");
            push_e(0, 0, 0, 0, 0, 1, "R2");
            mpc = p + 16'd1;
        end
        q[base].first = 1'b1;
        q[base].pc = p;
        q[base].sp = s;
        if (ovr != "") q[base].tag = ovr;
        ovr = "";
    endtask

    // memory model: reads settle half a clock after the address, writes at the edge
    always @(negedge clk) begin
        if ((^mem_addr) === 1'bx) mem_rdata <= 8'h00;
        else                      mem_rdata <= dut_byte(mem_addr);
    end

    always @(posedge clk) begin
        if (!rst && mem_wr === 1'b1) mem[int'(mem_addr)] = mem_wdata;
    end

    // per-state comparison against the model
    always @(negedge clk) begin
        ent_t e;
        if (rst) begin
            q.delete();
            mpc = '0;
            msp = '0;
            ovr = "R1";
        end else begin
            if (q.size() == 0) gen();
            e = q.pop_front();
            chk(e.tag, "mem_rd", 32'(mem_rd), 32'(e.rd));
            chk("R8", "mem_wr", 32'(mem_wr), 32'(e.wr));
            if (e.chk_addr) chk(e.tag, "mem_addr", 32'(mem_addr), 32'(e.addr));
            if (e.wr) begin
                chk("R8", "mem_wdata", 32'(mem_wdata), 32'(e.wd));
                mmem[int'(e.addr)] = e.wd;
            end
            chk("R10", "insn_end", 32'(insn_end), 32'(e.last));
            if (e.first) begin
                chk(e.tag, "pc_out", 32'(pc_out), 32'(e.pc));
                chk(e.tag, "sp_out", 32'(sp_out), 32'(e.sp));
            end
            if (ld_en) begin
                q.delete();
                mpc = ld_pc;
                msp = ld_sp;
                ovr = "R9";
            end
        end
    end

    task automatic load(logic [15:0] p, logic [15:0] s);
        #2;
        ld_pc = p;
        ld_sp = s;
        ld_en = 1'b1;
        @(posedge clk);
        #2 ld_en = 1'b0;
    endtask

    initial begin
        put(16'h2000, 8'hE4); put(16'h2001, 8'h10); put(16'h2002, 8'h20);
        put(16'h2010, 8'h00); put(16'h2011, 8'hC9);
        put(16'h2003, 8'hE4); put(16'h2004, 8'h30); put(16'h2005, 8'h20);
        put(16'h2006, 8'hE4); put(16'h2007, 8'h00); put(16'h2008, 8'h30);
        put(16'h3000, 8'hC9);
        put(16'h2100, 8'hE4); put(16'h2101, 8'h20); put(16'h2102, 8'h21);
        put(16'h2120, 8'hC9);
        put(16'h2200, 8'hC9);

        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        repeat (12) @(posedge clk);

        // taken call, return, skipped call, taken call, return
        load(16'h2000, 16'h5000);
        repeat (120) @(posedge clk);
        #1;
        chk("R5", "stack 4FFF", 32'(dut_byte(16'h4FFF)), 32'h20);
        chk("R5", "stack 4FFE", 32'(dut_byte(16'h4FFE)), 32'h09);
        chk("R4", "stack 4FFD untouched", 32'(dut_byte(16'h4FFD)), 32'h00);

        // push across the bottom of the address space
        load(16'h2100, 16'h0001);
        repeat (50) @(posedge clk);
        #1;
        chk("R7", "stack 0000", 32'(dut_byte(16'h0000)), 32'h21);
        chk("R7", "stack FFFF", 32'(dut_byte(16'hFFFF)), 32'h03);

        // pop starting at 0x0000
        load(16'h2200, 16'h0000);
        repeat (30) @(posedge clk);

        // load in the middle of a call abandons it
        load(16'h2000, 16'h5000);
        repeat (10) @(posedge clk);
        load(16'h2300, 16'h4000);
        repeat (20) @(posedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule